// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line-Break Flagging

The block turns an asynchronous serial line into bytes. The line is sampled 16 times per bit. A falling edge is checked again at the middle of the start bit. Each data bit is then captured at the middle of its own bit period, least significant bit first. An optional parity bit follows, then one stop bit. Each frame ends in one of three ways. A good frame loads the received byte and sets a ready flag, together with a parity-error flag when the parity bit does not match. A frame whose stop bit is low but which carries some high bit sets a framing-error flag. A frame in which every data bit, the parity bit and the stop bit are all low is treated as a line break.

A break raises the break flag at the moment its low stop bit is sampled. The receiver then waits for the line to return high. It raises the break flag a second time when it sees the end of the break. In the normal mode the end needs two consecutive high oversample ticks. A fast option accepts a single high tick, which suits lines driven from a clock-aligned source. Software can therefore clear the flag after the first report and catch both edges of the break.

All four flags are sticky. They stay set until the `status_clr` strobe is pulsed. The finite-state machine has six states: IDLE (line idle, waiting for a low tick), START (checking the start bit), DATA (shifting in bits), PAR (capturing parity), STOP (judging the stop bit) and BREAK (waiting for the line to rise). Its transitions are:
- IDLE→START when a tick sees a low line.
- START→IDLE when the line is high at the mid-start tick, or START→DATA when it is still low.
- DATA→PAR after the last data bit when parity is on, or DATA→STOP when parity is off.
- PAR→STOP.
- STOP→IDLE for a good frame or a framing error, or STOP→BREAK for an all-low frame.
- BREAK→IDLE on the end of the break.

Top module: `uart_brk_rx`

## Requirements
- R1: After reset `rx_data` is 0 and `rx_ready`, `rx_break`, `rx_perr` and `rx_ferr` are all 0.
- R2: A low pulse on `rxd_in` that has gone high again by the eighth oversample tick after it was first seen is dropped. No flag is set and the receiver returns to idle.
- R3: Data bits are taken least significant bit first, each at the middle tick of its period. When the stop bit is sampled high, the byte appears on `rx_data` and `rx_ready` is set. `rx_data` changes only together with the setting of `rx_ready`.
- R4: `par_mode` selects the parity: 2'b00 or 2'b11 means no parity bit, 2'b01 means even parity (data ones plus the parity bit give an even count), and 2'b10 means odd parity. A mismatch sets `rx_perr`, and the byte is still delivered with `rx_ready`.
- R5: A low stop bit in a frame that has some high data or parity bit sets `rx_ferr`. It leaves `rx_ready` and `rx_break` clear and leaves `rx_data` unchanged.
- R6: A frame with all data bits, the parity bit (when enabled) and the stop bit low sets `rx_break` when the stop bit is sampled. It does not set `rx_ready` and does not change `rx_data`.
- R7: With `brk_end_fast` = 0, the end of a break needs the line high on two consecutive oversample ticks, and then `rx_break` is set again. A single high tick followed by low does not end the break.
- R8: With `brk_end_fast` = 1, a single high oversample tick ends the break and sets `rx_break` again.
- R9: Every flag stays set until `status_clr` is pulsed. A clear pulse drops a flag that is not being set in the same cycle.
- R10: Once a break has ended, the receiver is idle and receives the next frame normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_in | input | 1 | Serial line, idle high |
| par_mode | input | 2 | 00/11 no parity, 01 even, 10 odd |
| brk_end_fast | input | 1 | 1: one high tick ends a break; 0: two ticks |
| status_clr | input | 1 | Strobe that clears all sticky flags |
| rx_data | output | DATA_W | Last good received byte |
| rx_ready | output | 1 | Sticky: a byte was received |
| rx_break | output | 1 | Sticky: break start or break end seen |
| rx_perr | output | 1 | Sticky: parity mismatch |
| rx_ferr | output | 1 | Sticky: low stop bit in a non-break frame |

## Verification
A wrong bit counter or a wrong oversample phase shows up as a corrupted byte, or as a false framing or parity flag, within the same frame, about one bit time after the stop bit. A stuck BREAK state shows up as a missing second `rx_break` report once the line has been high for a few ticks. It also shows up as the loss of the next byte, within one frame time. If the stop check is misjudged, a break is reported as a received byte or as a framing error, and `rx_data` changes at the stop-bit sample.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK
    } rx_state_t;

    localparam int OS_RATE  = 16;
    localparam int OS_CW    = $clog2(OS_RATE);
    localparam int FLAG_N   = 4;
    localparam int FLG_RDY  = 0;
    localparam int FLG_BRK  = 1;
    localparam int FLG_PERR = 2;
    localparam int FLG_FERR = 3;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int OS_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic os_tick
);

    localparam int CW = (OS_DIV > 1) ? $clog2(OS_DIV) : 1;

    generate
        if (OS_DIV <= 1) begin : g_every
            assign os_tick = 1'b1;
        end else begin : g_div
            localparam logic [CW-1:0] LAST = CW'(OS_DIV - 1);
            logic [CW-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign os_tick = (div_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= 1'b1;
                end else if (s == 0) begin
                    chain_q[s] <= d_in;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic [1:0]        par_mode,
    input  logic              brk_end_fast,
    output logic              load_evt,
    output logic [FLAG_N-1:0] flag_set,
    output logic [DATA_W-1:0] word_out
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);
    localparam logic [OS_CW-1:0] MID_LOAD = OS_CW'(OS_RATE / 2);
    localparam logic [OS_CW-1:0] SMP_CNT  = OS_CW'(OS_RATE - 1);

    rx_state_t          state_q, state_d;
    logic [OS_CW-1:0]   os_cnt_q;
    logic [IDX_W-1:0]   bit_idx_q;
    logic [DATA_W-1:0]  shreg_q;
    logic               zero_q;
    logic               par_bit_q;
    logic               hi_seen_q;

    logic smp;
    logic par_en;
    logic par_exp;
    logic brk_end;

    assign smp     = os_tick && (os_cnt_q == SMP_CNT);
    assign par_en  = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
    assign par_exp = (par_mode == PAR_EVEN) ? (^shreg_q) : ~(^shreg_q);
    assign brk_end = (state_q == ST_BRK) && os_tick && rxd
                     && (brk_end_fast || hi_seen_q);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (os_tick && !rxd) state_d = ST_START;
            ST_START: if (smp) state_d = rxd ? ST_IDLE : ST_DATA;
            ST_DATA:  if (smp && (bit_idx_q == LAST_IDX))
                          state_d = par_en ? ST_PAR : ST_STOP;
            ST_PAR:   if (smp) state_d = ST_STOP;
            ST_STOP:  if (smp) state_d = (!rxd && zero_q) ? ST_BRK : ST_IDLE;
            ST_BRK:   if (brk_end) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt_q  <= '0;
            bit_idx_q <= '0;
            shreg_q   <= '0;
            zero_q    <= 1'b0;
            par_bit_q <= 1'b0;
            hi_seen_q <= 1'b0;
        end else if (os_tick) begin
            hi_seen_q <= (state_q == ST_BRK) && rxd;
            case (state_q)
                ST_IDLE: begin
                    if (!rxd) os_cnt_q <= MID_LOAD;
                end
                ST_START: begin
                    os_cnt_q <= os_cnt_q + 1'b1;
                    if (smp) begin
                        bit_idx_q <= '0;
                        zero_q    <= 1'b1;
                    end
                end
                ST_DATA: begin
                    os_cnt_q <= os_cnt_q + 1'b1;
                    if (smp) begin
                        shreg_q   <= {rxd, shreg_q[DATA_W-1:1]};
                        zero_q    <= zero_q && !rxd;
                        bit_idx_q <= bit_idx_q + 1'b1;
                    end
                end
                ST_PAR: begin
                    os_cnt_q <= os_cnt_q + 1'b1;
                    if (smp) begin
                        par_bit_q <= rxd;
                        zero_q    <= zero_q && !rxd;
                    end
                end
                ST_STOP: begin
                    os_cnt_q <= os_cnt_q + 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        load_evt = 1'b0;
        flag_set = '0;
        if ((state_q == ST_STOP) && smp) begin
            if (rxd) begin
                load_evt           = 1'b1;
                flag_set[FLG_RDY]  = 1'b1;
                flag_set[FLG_PERR] = par_en && (par_bit_q != par_exp);
            end else if (zero_q) begin
                flag_set[FLG_BRK]  = 1'b1;
            end else begin
                flag_set[FLG_FERR] = 1'b1;
            end
        end
        if (brk_end) flag_set[FLG_BRK] = 1'b1;
    end

    assign word_out = shreg_q;

    // R2
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && os_tick && os_cnt_q == SMP_CNT && rxd)
        |=> (state_q == ST_IDLE));

    // R6
    brk_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && os_tick && os_cnt_q == SMP_CNT && !rxd && zero_q)
        |=> (state_q == ST_BRK));

    // R6
    brk_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BRK) |-> !load_evt);

    // R7
    async_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BRK && os_tick && rxd && !brk_end_fast && !hi_seen_q)
        |=> (state_q == ST_BRK));

    // R8
    fast_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BRK && os_tick && rxd && brk_end_fast)
        |=> (state_q == ST_IDLE));

endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [FLAG_N-1:0] flag_set,
    input  logic              load_evt,
    input  logic [DATA_W-1:0] word_in,
    output logic [FLAG_N-1:0] flags_out,
    output logic [DATA_W-1:0] data_out
);

    logic [DATA_W-1:0] data_q;

    generate
        for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
            logic f_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    f_q <= 1'b0;
                end else if (flag_set[g]) begin
                    f_q <= 1'b1;
                end else if (clr) begin
                    f_q <= 1'b0;
                end
            end

            assign flags_out[g] = f_q;

            // R9
            clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr && !flag_set[g]) |=> !flags_out[g]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_evt) begin
            data_q <= word_in;
        end
    end

    assign data_out = data_q;

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> flags_out[FLG_RDY]);

endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
    import uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OS_DIV      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_in,
    input  logic [1:0]        par_mode,
    input  logic              brk_end_fast,
    input  logic              status_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              rx_break,
    output logic              rx_perr,
    output logic              rx_ferr
);

    logic              rxd_s;
    logic              os_tick;
    logic              load_evt;
    logic [FLAG_N-1:0] flag_set;
    logic [FLAG_N-1:0] flags;
    logic [DATA_W-1:0] word;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rxd_in),
        .d_out (rxd_s)
    );

    uart_rx_tick #(.OS_DIV(OS_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick)
    );

    uart_rx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .os_tick      (os_tick),
        .rxd          (rxd_s),
        .par_mode     (par_mode),
        .brk_end_fast (brk_end_fast),
        .load_evt     (load_evt),
        .flag_set     (flag_set),
        .word_out     (word)
    );

    uart_rx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (status_clr),
        .flag_set  (flag_set),
        .load_evt  (load_evt),
        .word_in   (word),
        .flags_out (flags),
        .data_out  (rx_data)
    );

    assign rx_ready = flags[FLG_RDY];
    assign rx_break = flags[FLG_BRK];
    assign rx_perr  = flags[FLG_PERR];
    assign rx_ferr  = flags[FLG_FERR];

endmodule

// File: tb/uart_brk_rx_tb.sv
module uart_brk_rx_tb;

    localparam int OS_DIV = 4;
    localparam int TICK   = OS_DIV;
    localparam int BIT    = 16 * OS_DIV;
    localparam int NVEC   = 8;

    // {par_mode, flip_parity, data}
    localparam logic [10:0] VECS [0:NVEC-1] = '{
        {2'b00, 1'b0, 8'hA5},
        {2'b01, 1'b0, 8'h3C},
        {2'b10, 1'b0, 8'h01},
        {2'b01, 1'b1, 8'hFF},
        {2'b10, 1'b1, 8'h00},
        {2'b11, 1'b0, 8'h5A},
        {2'b00, 1'b0, 8'h00},
        {2'b10, 1'b0, 8'h80}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd_in = 1'b1;
    logic [1:0] par_mode = 2'b00;
    logic       brk_end_fast = 1'b0;
    logic       status_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, rx_break, rx_perr, rx_ferr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_brk_rx u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rxd_in       (rxd_in),
        .par_mode     (par_mode),
        .brk_end_fast (brk_end_fast),
        .status_clr   (status_clr),
        .rx_data      (rx_data),
        .rx_ready     (rx_ready),
        .rx_break     (rx_break),
        .rx_perr      (rx_perr),
        .rx_ferr      (rx_ferr)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rxd_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic [1:0] pm,
                              input logic flip, input logic stop_v);
        logic pb;
        par_mode = pm;
        hold(1'b0, BIT);
        for (int i = 0; i < 8; i++) hold(d[i], BIT);
        if (pm == 2'b01 || pm == 2'b10) begin
            pb = ((pm == 2'b01) ? (^d) : ~(^d)) ^ flip;
            hold(pb, BIT);
        end
        hold(stop_v, BIT);
        hold(1'b1, BIT);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] last;
        repeat (4) @(negedge clk);
        check("R1 data", int'(rx_data), 0);
        check("R1 flags", int'({rx_ready, rx_break, rx_perr, rx_ferr}), 0);
        rst_n = 1'b1;
        hold(1'b1, BIT);
        check("R1 idle flags", int'({rx_ready, rx_break, rx_perr, rx_ferr}), 0);

        // R2: short start glitch
        hold(1'b0, 4 * TICK);
        hold(1'b1, 2 * BIT);
        check("R2 glitch flags", int'({rx_ready, rx_break, rx_perr, rx_ferr}), 0);

        // R3 / R4 vector walk
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] pm;
            logic       fl;
            logic [7:0] dd;
            int         pe;
            {pm, fl, dd} = VECS[v];
            pe = (fl && (pm == 2'b01 || pm == 2'b10)) ? 1 : 0;
            pulse_clr();
            check("R9 cleared", int'(rx_ready), 0);
            send_frame(dd, pm, fl, 1'b1);
            check("R3 data", int'(rx_data), int'(dd));
            check("R3 ready", int'(rx_ready), 1);
            check("R4 parity err", int'(rx_perr), pe);
            check("R5 no ferr", int'(rx_ferr), 0);
        end
        last = VECS[NVEC-1][7:0];
        hold(1'b1, BIT);
        check("R9 sticky", int'(rx_ready), 1);

        // R5: low stop with odd parity bit high, data zero
        pulse_clr();
        send_frame(8'h00, 2'b10, 1'b0, 1'b0);
        check("R5 ferr", int'(rx_ferr), 1);
        check("R5 no ready", int'(rx_ready), 0);
        check("R5 no break", int'(rx_break), 0);
        check("R5 data kept", int'(rx_data), int'(last));
        pulse_clr();
        send_frame(8'h80, 2'b00, 1'b0, 1'b0);
        check("R5 ferr nopar", int'(rx_ferr), 1);
        check("R5 data kept2", int'(rx_data), int'(last));

        // R6 / R7: break with even parity, slow end
        pulse_clr();
        par_mode = 2'b01;
        brk_end_fast = 1'b0;
        hold(1'b0, 12 * BIT);
        check("R6 break start", int'(rx_break), 1);
        check("R6 no ready", int'(rx_ready), 0);
        check("R6 no ferr", int'(rx_ferr), 0);
        check("R6 data kept", int'(rx_data), int'(last));
        pulse_clr();
        check("R9 break cleared", int'(rx_break), 0);
        hold(1'b1, TICK);
        hold(1'b0, 4 * TICK);
        check("R7 one tick not end", int'(rx_break), 0);
        hold(1'b1, 3 * TICK);
        hold(1'b1, 2 * BIT);
        check("R7 break end", int'(rx_break), 1);

        // R10: normal frame after break
        pulse_clr();
        send_frame(8'h96, 2'b00, 1'b0, 1'b1);
        check("R10 data", int'(rx_data), 8'h96);
        check("R10 ready", int'(rx_ready), 1);
        check("R10 no break", int'(rx_break), 0);

        // R8: fast end of break, no parity
        pulse_clr();
        par_mode = 2'b00;
        brk_end_fast = 1'b1;
        hold(1'b0, 11 * BIT);
        check("R8 break start", int'(rx_break), 1);
        pulse_clr();
        hold(1'b1, TICK);
        hold(1'b0, 4 * TICK);
        check("R8 fast end", int'(rx_break), 1);
        hold(1'b1, 2 * BIT);
        check("R8 no ready", int'(rx_ready), 0);
        check("R8 no ferr", int'(rx_ferr), 0);
        send_frame(8'h4B, 2'b00, 1'b0, 1'b1);
        check("R10 data fast", int'(rx_data), 8'h4B);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule